// File: doc/BRIEF.md
# Conditional Skip Condition Evaluator

This block looks at one 16-bit instruction word and decides whether the instruction that follows it should be passed over. A word belongs to the skip class when its six most significant bits carry a fixed pattern. The ten bits below that pattern form a reverse flag and a mask of nine machine conditions. The conditions are the accumulator sign, the accumulator's least significant bit, an all-zero accumulator, a memory parity fault, four sense-switch levels and the carry bit.

The conditions picked out by the mask are combined with a logical AND. The reverse flag can then invert the result. With the mask empty the AND is true, so the word always skips, and with the reverse flag also set it never skips. The zero test is true when the accumulator is zero, not when it is nonzero. This means no single word can skip on a strictly positive value.

The evaluation is purely combinational from the current inputs. A `valid` strobe qualifies it, and the sequencer around the block samples it while the word is being executed. The block does no fetching and does not advance the program counter.

Top module: `skip_eval`

## Requirements
- R1: `isSkipInstr` is high exactly when `instrWord[15:10]` equals 6'b100000, regardless of `valid`.
- R2: `skipOut` is low whenever `valid` is low or the word is not a skip-class word.
- R3: A skip-class word with `instrWord[9:0]` all zero (octal 100000) skips for every accumulator, carry, fault and switch value.
- R4: Mask bit 8 (sign test) is satisfied only when `accum[ACC_W-1]` is 0.
- R5: Mask bit 6 (even test) is satisfied only when `accum[0]` is 0.
- R6: Mask bit 5 (zero test) is satisfied only when every bit of `accum` is 0, so octal 100040 skips exactly on a zero accumulator.
- R7: Mask bit 7 (parity-fault test) is satisfied only when `parityErr` is 1.
- R8: Mask bits 4, 3, 2 and 1 test switches 1 to 4 in that order, with switch n on `senseSw[n-1]`. Each is satisfied only when that switch input is 0.
- R9: Mask bit 0 (carry test) is satisfied only when `carryBit` is 0.
- R10: With bit 9 clear, a skip-class word skips only when every selected condition holds. Octal 100500 skips only on non-negative even values, and octal 100041 skips only when both the accumulator and the carry are zero.
- R11: Bit 9 inverts the decision. Octal 101000 never skips, and octal 101030 skips when switch 1 or switch 2 is 1.
- R12: Octal 101041 skips when the accumulator is nonzero or the carry is 1, and does not skip when both are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| valid | input | 1 | Qualifies the word as being executed this cycle |
| instrWord | input | 16 | Instruction word, bit 15 most significant |
| accum | input | ACC_W | Accumulator contents |
| carryBit | input | 1 | Carry flag |
| parityErr | input | 1 | Memory parity fault flag |
| senseSw | input | 4 | Sense switch levels, 1 = set, bit 0 = switch 1 |
| skipOut | output | 1 | High when the next instruction is to be skipped |
| isSkipInstr | output | 1 | High when the word is skip-class |

## Verification
The bench goes after how each mask bit is tied to its condition. If a switch index is swapped, or the carry and the even test are crossed, directed patterns with only one bit set skip on the wrong input. It also covers the empty mask, with and without reversal. A design that treats an empty mask as false would never skip on octal 100000 and would always skip on octal 101000. The zero-test polarity is checked with the reversed zero-and-carry word, because a nonzero-sense zero test flips those results. Finally, words whose upper bits are off by one bit must never raise the skip, which catches a loose decode.

// File: rtl/skip_pkg.sv
package skip_pkg;
  // Fixed instruction layout for the skip class
  localparam int WORD_W   = 16;
  localparam int OP_W     = 6;
  localparam logic [OP_W-1:0] SKIP_OP = 6'b100000;
  localparam int COND_N   = 9;
  localparam int NUM_SW   = 4;
  localparam int REV_BIT  = 9;

  // Condition positions inside the mask field
  localparam int CI_POS   = 8;
  localparam int CI_PERR  = 7;
  localparam int CI_EVEN  = 6;
  localparam int CI_ZERO  = 5;
  localparam int CI_SW1   = 4;
  localparam int CI_CARRY = 0;

  // Strobes from decode to evaluation
  typedef struct packed {
    logic              isSkip;
    logic              reverse;
    logic [COND_N-1:0] selMask;
  } skipCtrl_t;
endpackage

// File: rtl/skip_ctrl.sv
module skip_ctrl
  import skip_pkg::*;
(
  input  logic [WORD_W-1:0] instrWord,
  output skipCtrl_t         ctrl
);
  localparam int OP_LSB = WORD_W - OP_W;

  always_comb begin
    ctrl.isSkip  = (instrWord[WORD_W-1:OP_LSB] == SKIP_OP);
    ctrl.reverse = instrWord[REV_BIT];
    ctrl.selMask = instrWord[COND_N-1:0];
  end
endmodule

// File: rtl/skip_datapath.sv
module skip_datapath
  import skip_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  skipCtrl_t         ctrl,
  input  logic [ACC_W-1:0]  accum,
  input  logic              carryBit,
  input  logic              parityErr,
  input  logic [NUM_SW-1:0] senseSw,
  output logic              decision
);
  logic [COND_N-1:0] condMet;
  logic [COND_N-1:0] passVec;

  // Machine conditions other than the switches
  always_comb begin
    condMet[CI_POS]   = ~accum[ACC_W-1];
    condMet[CI_PERR]  = parityErr;
    condMet[CI_EVEN]  = ~accum[0];
    condMet[CI_ZERO]  = ~(|accum);
    condMet[CI_CARRY] = ~carryBit;
  end

  // One condition per sense switch: true while the switch is reset
  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign condMet[CI_SW1-i] = ~senseSw[i];
  end

  // Unselected conditions pass; selected ones must hold
  assign passVec  = condMet | ~ctrl.selMask;
  assign decision = (&passVec) ^ ctrl.reverse;
endmodule

// File: rtl/skip_eval.sv
module skip_eval
  import skip_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] instrWord,
  input  logic [ACC_W-1:0]  accum,
  input  logic              carryBit,
  input  logic              parityErr,
  input  logic [NUM_SW-1:0] senseSw,
  output logic              skipOut,
  output logic              isSkipInstr
);
  skipCtrl_t ctrl;
  logic      decision;

  skip_ctrl u_ctrl (
    .instrWord (instrWord),
    .ctrl      (ctrl)
  );

  skip_datapath #(.ACC_W(ACC_W)) u_dp (
    .ctrl      (ctrl),
    .accum     (accum),
    .carryBit  (carryBit),
    .parityErr (parityErr),
    .senseSw   (senseSw),
    .decision  (decision)
  );

  assign isSkipInstr = ctrl.isSkip;
  assign skipOut     = valid & ctrl.isSkip & decision;
endmodule

// File: rtl/skip_eval_chk.sv
module skip_eval_chk
  import skip_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input logic              valid,
  input logic [WORD_W-1:0] instrWord,
  input logic [ACC_W-1:0]  accum,
  input logic              carryBit,
  input logic              parityErr,
  input logic [NUM_SW-1:0] senseSw,
  input logic              skipOut,
  input logic              isSkipInstr
);
  always_comb begin
    if (!$isunknown({valid, instrWord, accum, carryBit, parityErr, senseSw, skipOut, isSkipInstr})) begin
      // R2: no skip without a valid skip-class word
      p_idle_quiet_r2: assert (!((!valid || !isSkipInstr) && skipOut));
      // R3: empty mask, no reverse, always skips
      p_empty_skips_r3: assert (!(valid && instrWord == 16'o100000 && !skipOut));
      // R11: reverse with empty mask never skips
      p_rev_never_r11: assert (!(instrWord == 16'o101000 && skipOut));
      // R6: a skip on a zero-only mask implies a zero accumulator
      p_zero_only_r6: assert (!(instrWord == 16'o100040 && skipOut && accum != '0));
      // R9: a skip on the carry test implies carry clear
      p_carry_r9: assert (!(skipOut && !instrWord[REV_BIT] && instrWord[CI_CARRY] && carryBit));
      // R4: a skip on the sign test implies a non-negative accumulator
      p_sign_r4: assert (!(skipOut && !instrWord[REV_BIT] && instrWord[CI_POS] && accum[ACC_W-1]));
    end
  end
endmodule

bind skip_eval skip_eval_chk #(.ACC_W(ACC_W)) u_chk (.*);

// File: tb/sim_skip_eval.sv
module sim_skip_eval;
  logic        clk = 1'b0;
  logic        valid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [15:0] accum = '0;
  logic        carryBit = 1'b0;
  logic        parityErr = 1'b0;
  logic [3:0]  senseSw = '0;
  logic        skipOut;
  logic        isSkipInstr;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  skip_eval u0 (
    .valid(valid), .instrWord(instrWord), .accum(accum), .carryBit(carryBit),
    .parityErr(parityErr), .senseSw(senseSw), .skipOut(skipOut), .isSkipInstr(isSkipInstr)
  );

  // Reference built from the requirement text
  function automatic bit refSkip(input logic [15:0] w, input logic [15:0] a, input bit c,
                                 input bit pe, input logic [3:0] sw, input bit v);
    logic [8:0] cond;
    if (!v || w[15:10] != 6'b100000) return 1'b0;
    cond[8] = ~a[15];
    cond[7] = pe;
    cond[6] = ~a[0];
    cond[5] = (a == 16'd0);
    cond[4] = ~sw[0];
    cond[3] = ~sw[1];
    cond[2] = ~sw[2];
    cond[1] = ~sw[3];
    cond[0] = ~c;
    return (&(cond | ~w[8:0])) ^ w[9];
  endfunction

  task automatic check(input bit got, input bit exp, input string tag);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s word=%o acc=%h c=%0d pe=%0d sw=%b got=%0d exp=%0d",
               tag, instrWord, accum, carryBit, parityErr, senseSw, got, exp);
    end
  endtask

  task automatic apply(input logic [15:0] w, input logic [15:0] a, input bit c,
                       input bit pe, input logic [3:0] sw, input bit v);
    @(negedge clk);
    instrWord = w; accum = a; carryBit = c; parityErr = pe; senseSw = sw; valid = v;
    #2;
  endtask

  task automatic dir(input logic [15:0] w, input logic [15:0] a, input bit c,
                     input bit pe, input logic [3:0] sw, input bit exp, input string tag);
    apply(w, a, c, pe, sw, 1'b1);
    check(skipOut, exp, tag);
    check(skipOut, refSkip(w, a, c, pe, sw, 1'b1), tag);
  endtask

  initial begin
    void'($urandom(32'd5169));
    // Idle state: nothing valid, no skip (R2)
    apply(16'o100000, 16'h0, 1'b0, 1'b0, 4'h0, 1'b0);
    check(skipOut, 1'b0, "R2 idle");
    check(isSkipInstr, 1'b1, "R1 decode ignores valid");
    // R1 decode boundaries
    apply(16'o140000, 16'h0, 1'b0, 1'b0, 4'h0, 1'b1);
    check(isSkipInstr, 1'b0, "R1 generic word");
    check(skipOut, 1'b0, "R2 generic word");
    apply(16'o102000, 16'h0, 1'b0, 1'b0, 4'h0, 1'b1);
    check(isSkipInstr, 1'b0, "R1 op bit 10 set");
    check(skipOut, 1'b0, "R2 op bit 10 set");
    apply(16'o000000, 16'h0, 1'b0, 1'b0, 4'h0, 1'b1);
    check(isSkipInstr, 1'b0, "R1 zero word");
    // R3
    dir(16'o100000, 16'hFFFF, 1'b1, 1'b1, 4'hF, 1'b1, "R3 empty mask");
    dir(16'o100000, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b1, "R3 empty mask low");
    // R4 sign
    dir(16'o100400, 16'h8000, 1'b0, 1'b0, 4'h0, 1'b0, "R4 negative");
    dir(16'o100400, 16'h0001, 1'b0, 1'b0, 4'h0, 1'b1, "R4 positive");
    dir(16'o100400, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b1, "R4 zero");
    // R5 even
    dir(16'o100100, 16'h0002, 1'b1, 1'b0, 4'h0, 1'b1, "R5 even");
    dir(16'o100100, 16'h0003, 1'b0, 1'b0, 4'h0, 1'b0, "R5 odd");
    // R6 zero
    dir(16'o100040, 16'h0000, 1'b1, 1'b0, 4'h0, 1'b1, "R6 zero");
    dir(16'o100040, 16'h0100, 1'b0, 1'b0, 4'h0, 1'b0, "R6 nonzero");
    // R7 parity fault
    dir(16'o100200, 16'h0000, 1'b0, 1'b1, 4'h0, 1'b1, "R7 fault");
    dir(16'o100200, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, "R7 no fault");
    // R8 switches, one at a time
    for (int n = 0; n < 4; n++) begin
      logic [15:0] w;
      w = 16'o100000 | (16'd1 << (4 - n));
      dir(w, 16'h1234, 1'b1, 1'b0, 4'h0, 1'b1, "R8 switch reset");
      dir(w, 16'h1234, 1'b1, 1'b0, 4'(1 << n), 1'b0, "R8 own switch set");
      dir(w, 16'h1234, 1'b1, 1'b0, ~4'(1 << n), 1'b1, "R8 other switches set");
    end
    // R9 carry
    dir(16'o100001, 16'h0005, 1'b0, 1'b0, 4'h0, 1'b1, "R9 carry clear");
    dir(16'o100001, 16'h0005, 1'b1, 1'b0, 4'h0, 1'b0, "R9 carry set");
    // R10 conjunction
    dir(16'o100500, 16'h0004, 1'b0, 1'b0, 4'h0, 1'b1, "R10 positive even");
    dir(16'o100500, 16'h0005, 1'b0, 1'b0, 4'h0, 1'b0, "R10 positive odd");
    dir(16'o100500, 16'h8004, 1'b0, 1'b0, 4'h0, 1'b0, "R10 negative even");
    dir(16'o100041, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b1, "R10 acc and c zero");
    dir(16'o100041, 16'h0000, 1'b1, 1'b0, 4'h0, 1'b0, "R10 c set");
    dir(16'o100041, 16'h0008, 1'b0, 1'b0, 4'h0, 1'b0, "R10 acc nonzero");
    // R11 reverse
    dir(16'o101000, 16'h0000, 1'b0, 1'b1, 4'h0, 1'b0, "R11 never");
    dir(16'o101030, 16'h0000, 1'b0, 1'b0, 4'b0001, 1'b1, "R11 sw1 set");
    dir(16'o101030, 16'h0000, 1'b0, 1'b0, 4'b0010, 1'b1, "R11 sw2 set");
    dir(16'o101030, 16'h0000, 1'b0, 1'b0, 4'b1100, 1'b0, "R11 sw1 sw2 reset");
    // R12 reversed zero-and-carry
    dir(16'o101041, 16'h0000, 1'b0, 1'b0, 4'h0, 1'b0, "R12 both zero");
    dir(16'o101041, 16'h0001, 1'b0, 1'b0, 4'h0, 1'b1, "R12 acc nonzero");
    dir(16'o101041, 16'h0000, 1'b1, 1'b0, 4'h0, 1'b1, "R12 c set");
    // R10 sweep of every low-bit pattern in several random environments
    for (int k = 0; k < 4; k++) begin
      for (int lo = 0; lo < 1024; lo++) begin
        logic [15:0] w, a;
        bit c, pe;
        logic [3:0] sw;
        w  = 16'o100000 | 16'(lo);
        a  = ($urandom % 4 == 0) ? 16'h0 : 16'($urandom);
        c  = 1'($urandom);
        pe = 1'($urandom);
        sw = 4'($urandom);
        apply(w, a, c, pe, sw, 1'b1);
        check(skipOut, refSkip(w, a, c, pe, sw, 1'b1), "R10 sweep");
      end
    end
    // R1/R2 random words, random valid
    for (int k = 0; k < 600; k++) begin
      logic [15:0] w;
      bit v;
      w = 16'($urandom);
      if (k % 3 == 0) w[15:10] = 6'b100000;
      v = 1'($urandom);
      apply(w, 16'($urandom), 1'($urandom), 1'($urandom), 4'($urandom), v);
      check(isSkipInstr, w[15:10] == 6'b100000, "R1 random decode");
      check(skipOut, refSkip(w, accum, carryBit, parityErr, senseSw, v), "R2 random qualify");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: run did not finish got=hung exp=done");
      end
    join_any
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule